// File: doc/BRIEF.md
# Endpoint Packet DMA Channel

This block is a single DMA channel. It drains one received packet from an endpoint buffer and hands it to an external DMA controller over a request/acknowledge handshake. It supports four endpoints. A one-byte control register selects the endpoint, the transfer unit (8-bit byte or 16-bit word), and the request style (single or demand). It also selects whether the packet length goes out ahead of the payload. A pause bit stops the request without losing the transfer position.

The endpoint buffer is seen through two combinational byte-read ports (the low lane and the high lane of the current unit), a per-endpoint ready flag and the length of the selected endpoint. A unit moves on every rising clock edge where `dreq` and `dack` are both high. After the final unit is accepted, the block gives a one-cycle completion pulse and a matching buffer-release pulse.

Top module: `epDmaChannel`

## Requirements
- R1: A hardware reset (`rstN` low) clears every control bit to 0 and leaves `dreq` and `pktDone` low. A USB bus reset (`busRst`) abandons any transfer in progress but leaves the control register value unchanged.
- R2: Control bit 0 is the enable. While it is 0, `dreq` is never high, even when the selected endpoint has a packet ready.
- R3: In byte mode (control bit 1 = 0), each unit carries the next buffer byte on `dmaData[7:0]` with `dmaData[15:8]` = 00h. Bytes go out in buffer order.
- R4: In word mode (control bit 1 = 1), each unit carries two consecutive buffer bytes: the earlier byte on bits 7:0 and the later byte on bits 15:8. For an odd-length packet, the last word has 00h in bits 15:8.
- R5: With control bit 4 set, the first unit is the packet length in bytes, with 00h in bits 15:8. The payload follows from buffer byte 0.
- R6: Control bits 6:5 select the endpoint by code: 0, 1, 2 and 3 stand for endpoints 1, 2, 4 and 5. The code is presented on `epSel`, and the channel arms only on `epReady[code]`.
- R7: In single mode (control bit 2 = 0), `dreq` is low in the cycle after each accepted unit. It rises again in the following cycle if units remain.
- R8: In demand mode (control bit 2 = 1), `dreq` stays high after an accepted unit while units remain and the channel is neither paused nor disabled.
- R9: While control bit 7 is 1, `dreq` is low and `dack` has no effect. Clearing bit 7 resumes with the unit after the last accepted one.
- R10: `dreq` rises only after the selected endpoint reports ready. In the cycle after the last unit is accepted, `pktDone` and `epRelease` are high for exactly one cycle.
- R11: A zero-length packet with header insertion moves exactly one unit of value 0. Without header insertion it moves no unit, and `pktDone` pulses in the cycle after the channel arms.
- R12: Control bit 3 (address mode) is stored and read back on `ctrlRdata`, but it has no effect on the transferred data or the handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low |
| busRst | input | 1 | USB bus reset: aborts the transfer and keeps the register |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write value |
| ctrlRdata | output | 8 | Control register contents |
| epReady | input | 4 | Packet-ready flag per endpoint code |
| epLen | input | LEN_W | Byte length of the packet in the selected endpoint |
| epSel | output | 2 | Selected endpoint code |
| epRdAddrLo | output | LEN_W | Buffer address of the low-lane byte |
| epRdDataLo | input | 8 | Buffer byte at `epRdAddrLo` |
| epRdAddrHi | output | LEN_W | Buffer address of the high-lane byte |
| epRdDataHi | input | 8 | Buffer byte at `epRdAddrHi` |
| epRelease | output | 1 | One-cycle pulse that frees the endpoint buffer |
| dreq | output | 1 | Transfer request to the DMA controller |
| dack | input | 1 | Transfer acknowledge from the DMA controller |
| dmaData | output | 16 | Current transfer unit |
| pktDone | output | 1 | One-cycle packet-complete pulse |

## Verification
A wrong byte pointer or lost header flag shows up on `dmaData` in the very next unit offered after the fault. This happens as a shifted, repeated or missing byte against the buffer contents, or as a length value where payload belongs. A wrong unit count or end-of-packet decision shows within one cycle of the true last unit: either `pktDone` arrives early, or `dreq` stays high beyond the expected number of units. Handshake faults such as a missing single-mode gap, a request during pause, or a dropped position after resume appear at `dreq` one cycle after the triggering acknowledge or register write.

// File: rtl/epDmaPkg.sv
package epDmaPkg;

  typedef struct packed {
    logic       pause;
    logic [1:0] epSel;
    logic       hdr;
    logic       dualAddr;
    logic       demand;
    logic       wide;
    logic       en;
  } ctrlT;

  typedef struct packed {
    logic load;
    logic advance;
  } strobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } stateT;

endpackage

// File: rtl/epDmaCsr.sv
module epDmaCsr
  import epDmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  output ctrlT       ctrl
);

  ctrlT ctrlQ;

  // Only a hardware reset clears the register; bus reset does not reach it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWe) begin
      ctrlQ <= ctrlT'(ctrlWdata);
    end
  end

  assign ctrl = ctrlQ;

endmodule

// File: rtl/epDmaCtrl.sv
module epDmaCtrl
  import epDmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRst,
  input  logic       en,
  input  logic       pause,
  input  logic       demand,
  input  logic       hdr,
  input  logic [1:0] epSelCode,
  input  logic [3:0] epReady,
  input  logic       epLenZero,
  input  logic       lastUnit,
  input  logic       dack,
  output strobeT     strobe,
  output logic       dreq,
  output logic       pktDone,
  output logic       epRelease
);

  stateT stateQ, stateNext;
  logic  gapQ;
  logic  fire;

  assign dreq = (stateQ == ST_XFER) && en && !pause && !gapQ;
  assign fire = dreq && dack;

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (en && !pause && epReady[epSelCode]) begin
          strobe.load = 1'b1;
          stateNext   = (epLenZero && !hdr) ? ST_DONE : ST_XFER;
        end
      end
      ST_XFER: begin
        if (fire) begin
          strobe.advance = 1'b1;
          if (lastUnit) begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      gapQ   <= 1'b0;
    end else if (busRst) begin
      stateQ <= ST_IDLE;
      gapQ   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      gapQ   <= fire && !demand;
    end
  end

  assign pktDone   = (stateQ == ST_DONE);
  assign epRelease = (stateQ == ST_DONE);

endmodule

// File: rtl/epDmaDatapath.sv
module epDmaDatapath
  import epDmaPkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic             hdrIn,
  input  logic             wideIn,
  input  logic [LEN_W-1:0] epLen,
  output logic [LEN_W-1:0] rdAddrLo,
  input  logic [7:0]       rdDataLo,
  output logic [LEN_W-1:0] rdAddrHi,
  input  logic [7:0]       rdDataHi,
  output logic             lastUnit,
  output logic [15:0]      unitData
);

  localparam int PW = LEN_W + 1;

  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] ptrQ;
  logic             hdrQ;
  logic             wideQ;
  logic [PW-1:0]    ptrNext;
  logic [PW-1:0]    ptrPlusOne;
  logic             hiValid;
  logic [7:0]       lenByte;

  assign ptrNext    = {1'b0, ptrQ} + (wideQ ? PW'(2) : PW'(1));
  assign ptrPlusOne = {1'b0, ptrQ} + PW'(1);
  assign hiValid    = ptrPlusOne < {1'b0, lenQ};
  assign lenByte    = 8'(lenQ);

  assign rdAddrLo = ptrQ;
  assign rdAddrHi = ptrPlusOne[LEN_W-1:0];

  // Header is last only for an empty packet; payload is last when the step reaches the length.
  assign lastUnit = hdrQ ? (lenQ == '0) : (ptrNext >= {1'b0, lenQ});

  always_comb begin
    if (hdrQ) begin
      unitData = {8'h00, lenByte};
    end else begin
      unitData = {(wideQ && hiValid) ? rdDataHi : 8'h00, rdDataLo};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ  <= '0;
      ptrQ  <= '0;
      hdrQ  <= 1'b0;
      wideQ <= 1'b0;
    end else if (strobe.load) begin
      lenQ  <= epLen;
      ptrQ  <= '0;
      hdrQ  <= hdrIn;
      wideQ <= wideIn;
    end else if (strobe.advance) begin
      if (hdrQ) begin
        hdrQ <= 1'b0;
      end else begin
        ptrQ <= ptrNext[LEN_W-1:0];
      end
    end
  end

endmodule

// File: rtl/epDmaChannel.sv
module epDmaChannel
  import epDmaPkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int LEN_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busRst,
  input  logic             ctrlWe,
  input  logic [7:0]       ctrlWdata,
  output logic [7:0]       ctrlRdata,
  input  logic [3:0]       epReady,
  input  logic [LEN_W-1:0] epLen,
  output logic [1:0]       epSel,
  output logic [LEN_W-1:0] epRdAddrLo,
  input  logic [7:0]       epRdDataLo,
  output logic [LEN_W-1:0] epRdAddrHi,
  input  logic [7:0]       epRdDataHi,
  output logic             epRelease,
  output logic             dreq,
  input  logic             dack,
  output logic [15:0]      dmaData,
  output logic             pktDone
);

  ctrlT   ctrl;
  strobeT strobe;
  logic   lastUnit;

  epDmaCsr u_csr (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .ctrl      (ctrl)
  );

  epDmaCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busRst    (busRst),
    .en        (ctrl.en),
    .pause     (ctrl.pause),
    .demand    (ctrl.demand),
    .hdr       (ctrl.hdr),
    .epSelCode (ctrl.epSel),
    .epReady   (epReady),
    .epLenZero (epLen == '0),
    .lastUnit  (lastUnit),
    .dack      (dack),
    .strobe    (strobe),
    .dreq      (dreq),
    .pktDone   (pktDone),
    .epRelease (epRelease)
  );

  epDmaDatapath #(.LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hdrIn    (ctrl.hdr),
    .wideIn   (ctrl.wide),
    .epLen    (epLen),
    .rdAddrLo (epRdAddrLo),
    .rdDataLo (epRdDataLo),
    .rdAddrHi (epRdAddrHi),
    .rdDataHi (epRdDataHi),
    .lastUnit (lastUnit),
    .unitData (dmaData)
  );

  assign ctrlRdata = ctrl;
  assign epSel     = ctrl.epSel;

endmodule

// File: rtl/epDmaChannelChk.sv
module epDmaChannelChk (
  input logic        clk,
  input logic        rstN,
  input logic        busRst,
  input logic [7:0]  ctrlRdata,
  input logic        dreq,
  input logic        dack,
  input logic [15:0] dmaData,
  input logic        pktDone
);

  a_r2_no_dreq_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdata[0] |-> !dreq);

  a_r9_no_dreq_paused: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[7] |-> !dreq);

  a_r7_single_gap: assert property (@(posedge clk) disable iff (!rstN)
    (dreq && dack && !ctrlRdata[2]) |=> !dreq);

  a_r8_demand_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dreq && dack && ctrlRdata[2]) |=>
      (dreq || pktDone || !$stable(ctrlRdata) || $past(busRst)));

  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dreq && !ctrlRdata[1]) |-> (dmaData[15:8] == 8'h00));

  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);

endmodule

bind epDmaChannel epDmaChannelChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busRst    (busRst),
  .ctrlRdata (ctrlRdata),
  .dreq      (dreq),
  .dack      (dack),
  .dmaData   (dmaData),
  .pktDone   (pktDone)
);

// File: tb/epDmaChannel_tb.sv
module epDmaChannel_tb;

  localparam int LEN_W = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busRst = 1'b0;
  logic             ctrlWe = 1'b0;
  logic [7:0]       ctrlWdata = '0;
  logic [7:0]       ctrlRdata;
  logic [3:0]       epReady = '0;
  logic [LEN_W-1:0] epLen;
  logic [1:0]       epSel;
  logic [LEN_W-1:0] epRdAddrLo, epRdAddrHi;
  logic [7:0]       epRdDataLo, epRdDataHi;
  logic             epRelease, dreq, pktDone;
  logic             dack = 1'b0;
  logic [15:0]      dmaData;

  logic [7:0]       mem [4][64];
  logic [LEN_W-1:0] lenArr [4];

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign epLen      = lenArr[epSel];
  assign epRdDataLo = mem[epSel][epRdAddrLo[5:0]];
  assign epRdDataHi = mem[epSel][epRdAddrHi[5:0]];

  epDmaChannel u_dut (
    .clk(clk), .rstN(rstN), .busRst(busRst),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .epReady(epReady), .epLen(epLen), .epSel(epSel),
    .epRdAddrLo(epRdAddrLo), .epRdDataLo(epRdDataLo),
    .epRdAddrHi(epRdAddrHi), .epRdDataHi(epRdDataHi),
    .epRelease(epRelease), .dreq(dreq), .dack(dack),
    .dmaData(dmaData), .pktDone(pktDone)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk);
    ctrlWe = 1'b1;
    ctrlWdata = v;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  function automatic logic [15:0] expUnit(int ep, int len, bit wide, bit hdr, int idx);
    int i;
    int b;
    logic [7:0] hi;
    i = idx;
    if (hdr) begin
      if (i == 0) return {8'h00, 8'(len)};
      i--;
    end
    if (!wide) return {8'h00, mem[ep][i]};
    b = 2 * i;
    hi = (b + 1 < len) ? mem[ep][b + 1] : 8'h00;
    return {hi, mem[ep][b]};
  endfunction

  function automatic int unitCount(int len, bit wide, bit hdr);
    return (hdr ? 1 : 0) + (wide ? (len + 1) / 2 : len);
  endfunction

  // cfg bits: 0 en, 1 wide, 2 demand, 3 addr mode, 4 header, 6:5 endpoint code, 7 pause
  task automatic runPacket(input logic [7:0] cfgIn, input int ep, input int len,
                           input int dackPct, input int pauseAt);
    logic [7:0] cfg;
    bit wide, demand, hdr, prevAcc, paused, done;
    int n, got, cyc;
    string lbl;
    cfg = (cfgIn & 8'h1E) | 8'h01 | 8'(ep << 5);
    wide = cfg[1]; demand = cfg[2]; hdr = cfg[4];
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 64; j++) mem[k][j] = 8'($urandom);
    lenArr[ep] = LEN_W'(len);
    writeCtrl(cfg);
    check(epSel == 2'(ep), "R6 endpoint code on epSel", 32'(epSel), 32'(ep));
    @(negedge clk);
    check(!dreq, "R10 no request before ready", 32'(dreq), 0);
    epReady[ep] = 1'b1;
    n = unitCount(len, wide, hdr);
    got = 0; prevAcc = 0; paused = 0; done = 0; cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      ctrlWe = 1'b0;
      dack = 1'b0;
      if (pktDone) begin
        done = 1;
        check(epRelease, "R10 release with done", 32'(epRelease), 1);
        epReady[ep] = 1'b0;
      end else begin
        if (prevAcc && !demand) check(!dreq, "R7 single-mode gap", 32'(dreq), 0);
        if (prevAcc && demand && got < n) check(dreq, "R8 demand hold", 32'(dreq), 1);
        prevAcc = 0;
        if (pauseAt >= 0 && got == pauseAt && !paused && got < n) begin
          paused = 1;
          ctrlWe = 1'b1;
          ctrlWdata = cfg | 8'h80;
          for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            ctrlWe = 1'b0;
            dack = 1'b1;
            check(!dreq, "R9 paused request low", 32'(dreq), 0);
          end
          @(negedge clk);
          dack = 1'b0;
          ctrlWe = 1'b1;
          ctrlWdata = cfg;
        end else if (dreq) begin
          if (got >= n) begin
            check(0, "R10 request beyond last unit", got, n);
            done = 1;
          end else if (($urandom % 100) < dackPct) begin
            dack = 1'b1;
            lbl = (hdr && got == 0) ? "R5 header unit" : (wide ? "R4 word unit" : "R3 byte unit");
            if (len == 0 && hdr) lbl = "R11 zero-length header";
            check(dmaData == expUnit(ep, len, wide, hdr, got), lbl,
                  32'(dmaData), 32'(expUnit(ep, len, wide, hdr, got)));
            got++;
            prevAcc = 1;
          end
        end
      end
    end
    dack = 1'b0;
    check(done, "R10 packet done seen", 32'(done), 1);
    check(got == n, (len == 0) ? "R11 unit count" : "R10 unit count", got, n);
    @(negedge clk);
    check(!pktDone, "R10 done is one cycle", 32'(pktDone), 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int k = 0; k < 4; k++) lenArr[k] = '0;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 64; j++) mem[k][j] = '0;

    repeat (3) @(negedge clk);
    check(ctrlRdata == 8'h00, "R1 reset control value", 32'(ctrlRdata), 0);
    check(!dreq && !pktDone, "R1 reset outputs low", {30'd0, dreq, pktDone}, 0);
    rstN = 1'b1;

    // R2: disabled channel with a ready packet never requests
    lenArr[1] = 7'd5;
    epReady[1] = 1'b1;
    writeCtrl(8'h20 | 8'h02);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(!dreq, "R2 disabled no request", 32'(dreq), 0);
    end
    epReady[1] = 1'b0;
    @(negedge clk);

    // Directed corners
    runPacket(8'h00, 0, 1, 100, -1);   // R3 single byte
    runPacket(8'h02, 1, 7, 100, -1);   // R4 odd word
    runPacket(8'h06, 2, 8, 100, -1);   // R4 even word, demand
    runPacket(8'h12, 3, 5, 100, -1);   // R5 header + odd word
    runPacket(8'h14, 0, 64, 100, -1);  // R5 header, byte, max length
    runPacket(8'h10, 1, 0, 100, -1);   // R11 zero length with header
    runPacket(8'h12, 2, 0, 100, -1);   // R11 zero length with header, word
    runPacket(8'h00, 3, 0, 100, -1);   // R11 zero length, no header
    runPacket(8'h06, 0, 20, 100, 4);   // R9 pause in demand mode
    runPacket(8'h12, 1, 9, 70, 0);     // R9 pause before header
    runPacket(8'h08, 2, 6, 100, -1);   // R12 address-mode bit set
    check(ctrlRdata[3], "R12 address-mode bit stored", 32'(ctrlRdata), 32'h49);

    // R1: bus reset mid-transfer keeps register, drops request
    for (int j = 0; j < 64; j++) mem[2][j] = 8'(j);
    lenArr[2] = 7'd10;
    writeCtrl(8'h45);
    epReady[2] = 1'b1;
    @(negedge clk);
    dack = 1'b1;
    @(negedge clk);
    dack = 1'b0;
    busRst = 1'b1;
    epReady[2] = 1'b0;
    @(negedge clk);
    busRst = 1'b0;
    check(!dreq, "R1 bus reset stops request", 32'(dreq), 0);
    check(ctrlRdata == 8'h45, "R1 bus reset keeps register", 32'(ctrlRdata), 32'h45);
    @(negedge clk);

    // Random packets
    for (int t = 0; t < 40; t++) begin
      runPacket(8'($urandom) & 8'h1E, int'($urandom % 4), int'($urandom % 65),
                30 + int'($urandom % 71), ((t % 5) == 0) ? int'($urandom % 4) : -1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule